// File: doc/BRIEF.md
# Block-Lookahead Binary Adder

This block adds two unsigned operands of a configurable width together with a single carry-in. It returns a sum of the same width and a carry-out. It has no clock and no internal state, so the result follows the inputs through combinational logic only. It is meant to sit in a datapath wherever a full-width add must settle faster than a plain bit-serial carry chain allows.

The operands are cut into equal slices. Each slice computes a slice-level generate term and a slice-level propagate term from its own column terms. The carry into the next slice is then one AND-OR step away from the carry into the current slice. Inside a slice, the sum bits still come from a short chain of full adders that starts from the slice's incoming carry. The default width is 32 bits with 4-bit slices, which gives eight slices linked through the lookahead chain.

Top module: `cla_adder`

## Requirements
- R1: For every input combination, {carry_out, sum_out} equals op_a + op_b + carry_in, taken as an unsigned sum of WIDTH+1 bits (default WIDTH=32, BLK=4).
- R2: With both operands zero, the sum is 0 and carry_out is 0 when carry_in is 0; the sum is 1 and carry_out is 0 when carry_in is 1.
- R3: A carry that arises inside slice 0 (bits 3..0) reaches slice 1, so 0x0000000F + 0x00000001 with carry_in 0 gives 0x00000010 and carry_out 0.
- R4: A carry-in passes through every slice when all slices propagate, so 0xFFFFFFFF + 0x00000000 with carry_in 1 gives 0 and carry_out 1.
- R5: All ones plus all ones plus carry_in 1 gives all ones and carry_out 1.
- R6: 0xAAAAAAAA + 0x55555555 gives 0xFFFFFFFF with carry_out 0 when carry_in is 0, and gives 0 with carry_out 1 when carry_in is 1.
- R7: A slice whose propagate term is 0 blocks the incoming carry. With op_a = 0xFFFFFFF0 and op_b = 0, changing carry_in changes only bit 0 of the sum, and carry_out stays 0.
- R8: Any WIDTH that is an integer multiple of BLK gives a correct adder, for example WIDTH=6 with BLK=3. A WIDTH that is not a multiple of BLK is refused at elaboration.
- R9: Each slice sends on the carry G + P·Cin, where G is set when the slice overflows with a zero carry-in and P is set when every column has at least one operand bit set. So 0x00000070 + 0x00000090 gives 0x00000100: slice 1 generates a carry, and it lands in slice 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Low WIDTH bits of the sum |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The checks inside the slices compare results within one combinational evaluation. They assume that op_a, op_b and carry_in are known 0/1 values and that they stay stable while the logic settles. The bench meets this by driving every operand and the carry-in at the falling edge, all together, always with defined values, and by sampling only after a short delay. The slice-to-slice check also assumes that each slice's carry chain has settled before the top-level lookahead is compared with it. For that reason every stimulus step gives the outputs time to settle before anything is read.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Slice-level carry terms: gen = carry out with zero carry-in,
    // prop = carry-in would pass through the slice.
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    // Carry leaving a slice, given its terms and the carry entering it.
    function automatic logic carry_through(gp_t t, logic cin);
        return t.gen | (t.prop & cin);
    endfunction

endpackage

// File: rtl/cla_blk_gp.sv
module cla_blk_gp
    import cla_pkg::*;
#(
    parameter int BLK = 4
) (
    input  logic [BLK-1:0] a,
    input  logic [BLK-1:0] b,
    output gp_t            gp
);

    gp_t         gp_d;
    logic [BLK:0] wrap0_d;
    logic [BLK:0] wrap1_d;

    always_comb begin
        gp_d.gen  = 1'b0;
        gp_d.prop = 1'b1;
        for (int i = 0; i < BLK; i++) begin
            gp_d.gen  = (a[i] & b[i]) | ((a[i] | b[i]) & gp_d.gen);
            gp_d.prop = gp_d.prop & (a[i] | b[i]);
        end
        wrap0_d = {1'b0, a} + {1'b0, b};
        wrap1_d = {1'b0, a} + {1'b0, b} + {{BLK{1'b0}}, 1'b1};
        // R9
        blk_gen_chk: assert (gp_d.gen == wrap0_d[BLK])
            else $error("slice generate differs from arithmetic carry");
        // R9
        blk_prop_chk: assert ((gp_d.gen | gp_d.prop) == wrap1_d[BLK])
            else $error("slice propagate differs from arithmetic carry");
    end

    assign gp = gp_d;

endmodule

// File: rtl/cla_blk_sum.sv
module cla_blk_sum #(
    parameter int BLK = 4
) (
    input  logic [BLK-1:0] a,
    input  logic [BLK-1:0] b,
    input  logic           cin,
    output logic [BLK-1:0] sum,
    output logic           cout
);

    logic [BLK-1:0] sum_d;
    logic           c_d;
    logic [BLK:0]   ref_d;

    always_comb begin
        c_d = cin;
        for (int i = 0; i < BLK; i++) begin
            sum_d[i] = a[i] ^ b[i] ^ c_d;
            c_d      = (a[i] & b[i]) | (c_d & (a[i] ^ b[i]));
        end
        ref_d = {1'b0, a} + {1'b0, b} + {{BLK{1'b0}}, cin};
        // R1
        blk_sum_chk: assert ({c_d, sum_d} == ref_d)
            else $error("slice ripple result wrong");
    end

    assign sum  = sum_d;
    assign cout = c_d;

endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int BLK   = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int NBLK = WIDTH / BLK;

    // R8: refuse a width that does not split into whole slices
    if ((WIDTH % BLK) != 0 || BLK < 1) begin : g_bad_split
        $error("WIDTH must be a positive multiple of BLK");
    end

    gp_t          gp_arr [NBLK];
    logic [NBLK:0] blk_c_d;
    logic [NBLK-1:0] rip_co;

    for (genvar j = 0; j < NBLK; j++) begin : g_slice
        cla_blk_gp #(.BLK(BLK)) u_gp (
            .a  (op_a[j*BLK +: BLK]),
            .b  (op_b[j*BLK +: BLK]),
            .gp (gp_arr[j])
        );
        cla_blk_sum #(.BLK(BLK)) u_sum (
            .a    (op_a[j*BLK +: BLK]),
            .b    (op_b[j*BLK +: BLK]),
            .cin  (blk_c_d[j]),
            .sum  (sum_out[j*BLK +: BLK]),
            .cout (rip_co[j])
        );
    end

    // Lookahead chain: one AND-OR step per slice
    always_comb begin
        blk_c_d[0] = carry_in;
        for (int j = 0; j < NBLK; j++) begin
            blk_c_d[j+1] = carry_through(gp_arr[j], blk_c_d[j]);
        end
    end

    // Cross-check the skip path against each slice's own ripple carry
    always_comb begin
        for (int j = 0; j < NBLK; j++) begin
            // R9
            carry_link_chk: assert (rip_co[j] == blk_c_d[j+1])
                else $error("lookahead carry disagrees with slice ripple");
            // R7
            carry_stop_chk: assert (gp_arr[j].prop || (blk_c_d[j+1] == gp_arr[j].gen))
                else $error("blocked slice passed its carry-in");
        end
    end

    assign carry_out = blk_c_d[NBLK];

endmodule

// File: tb/sim_cla_adder.sv
module sim_cla_adder;

    localparam int CLK_PERIOD = 10;
    localparam int W0 = 32;
    localparam int W1 = 6;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    logic [W0-1:0] a0, b0, s0;
    logic          ci0, co0;
    logic [W1-1:0] a1, b1, s1;
    logic          ci1, co1;

    cla_adder #(.WIDTH(W0), .BLK(4)) u0 (
        .op_a(a0), .op_b(b0), .carry_in(ci0), .sum_out(s0), .carry_out(co0)
    );

    cla_adder #(.WIDTH(W1), .BLK(3)) u1 (
        .op_a(a1), .op_b(b1), .carry_in(ci1), .sum_out(s1), .carry_out(co1)
    );

    task automatic apply32(input logic [W0-1:0] a, input logic [W0-1:0] b,
                           input logic ci, input string req);
        logic [W0:0] exp;
        @(negedge clk);
        a0 = a; b0 = b; ci0 = ci;
        #1;
        exp = {1'b0, a} + {1'b0, b} + {{W0{1'b0}}, ci};
        total++;
        if ({co0, s0} !== exp) begin
            bad++;
            $display("FAIL %s: a=%h b=%h ci=%0b got=%h exp=%h", req, a, b, ci, {co0, s0}, exp);
        end
    endtask

    // R2
    task automatic t_zero();
        apply32('0, '0, 1'b0, "R2");
        apply32('0, '0, 1'b1, "R2");
    endtask

    // R3
    task automatic t_block_carry();
        apply32(32'h0000000F, 32'h00000001, 1'b0, "R3");
        apply32(32'h0000000F, 32'h00000000, 1'b1, "R3");
    endtask

    // R4
    task automatic t_full_skip();
        apply32(32'hFFFFFFFF, 32'h00000000, 1'b1, "R4");
        apply32(32'h00000000, 32'hFFFFFFFF, 1'b1, "R4");
    endtask

    // R5
    task automatic t_all_ones();
        apply32(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R5");
        apply32(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R5");
    endtask

    // R6
    task automatic t_alternate();
        apply32(32'hAAAAAAAA, 32'h55555555, 1'b0, "R6");
        apply32(32'hAAAAAAAA, 32'h55555555, 1'b1, "R6");
        apply32(32'h55555555, 32'h55555555, 1'b1, "R6");
    endtask

    // R7: slice 0 has propagate 0, so carry_in may only touch bit 0
    task automatic t_blocked();
        logic [W0-1:0] first;
        apply32(32'hFFFFFFF0, 32'h00000000, 1'b0, "R7");
        first = s0;
        apply32(32'hFFFFFFF0, 32'h00000000, 1'b1, "R7");
        total++;
        if ((s0 ^ first) !== 32'h00000001 || co0 !== 1'b0) begin
            bad++;
            $display("FAIL R7: diff=%h co=%0b exp diff=00000001 co=0", s0 ^ first, co0);
        end
    endtask

    // R9
    task automatic t_generate();
        apply32(32'h00000070, 32'h00000090, 1'b0, "R9");
        apply32(32'h0F000000, 32'h01000000, 1'b0, "R9");
        apply32(32'hF0000000, 32'h10000000, 1'b0, "R9");
    endtask

    // R1
    task automatic t_random();
        for (int n = 0; n < 3000; n++) begin
            apply32($urandom, $urandom, 1'($urandom), "R1");
        end
    endtask

    // R8: exhaustive on a 6-bit adder with 3-bit slices
    task automatic t_small_exhaustive();
        for (int v = 0; v < (1 << (2*W1+1)); v++) begin
            logic [W1:0] exp;
            @(negedge clk);
            a1  = v[W1-1:0];
            b1  = v[2*W1-1:W1];
            ci1 = v[2*W1];
            #1;
            exp = {1'b0, a1} + {1'b0, b1} + {{W1{1'b0}}, ci1};
            total++;
            if ({co1, s1} !== exp) begin
                bad++;
                $display("FAIL R8: a=%h b=%h ci=%0b got=%h exp=%h", a1, b1, ci1, {co1, s1}, exp);
            end
        end
    endtask

    initial begin
        a0 = '0; b0 = '0; ci0 = 1'b0;
        a1 = '0; b1 = '0; ci1 = 1'b0;
        t_zero();
        t_block_carry();
        t_full_skip();
        t_all_ones();
        t_alternate();
        t_blocked();
        t_generate();
        t_random();
        t_small_exhaustive();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d exp<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule